// File: doc/BRIEF.md
# Hot-Tile Bank Force Trigger

This block sits beside the graphics-side address bus of a tile-based video system. It watches for pattern fetches whose tile number equals one of several programmed "hot" tile numbers. When such a fetch occurs, the block can do two things. It can replace the normal character bank with a programmed forced bank. It can also pull an active-low interrupt request to the CPU. A mode register picks bank forcing only, interrupt only, both, or neither.

Both effects persist until one shared release event: a CPU write to a dedicated acknowledge address. That single write drops the interrupt and stops the bank override. Software that wants only the bank effect in the combined mode must mask the interrupt itself.

The tile number comes from the fetch address, so the bank switch lands at pixel precision. It can happen many times per line and is independent of scrolling. Sprite pattern fetches are issued at the end of a line in sprite index order. A sprite-triggered match therefore follows vertical position and sprite index, not horizontal position.

Top module: `hot_tile_trigger`

## Requirements
- R1: After reset the interrupt output is high (inactive) and the bank output equals the normal bank input. The hot tiles, the forced bank and the mode all reset to zero.
- R2: A match is a cycle with the read strobe high, graphics address bit 13 low, address bit 12 equal to mode bit 2, and address bits [11:4] equal to any hot tile register. Address bits [3:0] do not take part in the match.
- R3: A read with the wrong table bit, a wrong tile number, address bit 13 high, or the read strobe low changes neither output.
- R4: With mode bit 0 set, on the clock edge after a match the bank output shows the forced bank register. It keeps showing it until release, whatever the normal bank input does.
- R5: With mode bit 1 set, on the clock edge after a match the interrupt output goes low. It stays low until release.
- R6: With mode bits 0 and 1 both set, one match produces both effects on the same edge.
- R7: A CPU write to address 4 (acknowledge) clears both the interrupt and the bank override on the next edge. If the acknowledge and a match fall in the same cycle, the acknowledge wins.
- R8: With mode bits 0 and 1 both clear, matches have no effect on either output.
- R9: While the override is active, a new value written to the forced bank register appears on the bank output from the next edge.
- R10: While no override is active, the bank output follows the normal bank input in the same cycle.
- R11: The CPU register addresses are fixed. Address 0 and address 1 hold hot tiles 0 and 1. Address 2 holds the forced bank in data bits [3:0]. Address 3 holds the mode, with bit 0 for the bank override, bit 1 for the interrupt and bit 2 for the pattern table select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_wr_en | input | 1 | CPU register write strobe |
| cpu_wr_addr | input | 3 | CPU register address |
| cpu_wr_data | input | 8 | CPU register write data |
| gfx_addr | input | 14 | Graphics bus address |
| gfx_rd | input | 1 | Graphics read strobe, high for one fetch cycle |
| base_bank | input | 4 | Normal character bank from the surrounding bank logic |
| bank_out | output | 4 | Character bank to use for the current fetch |
| irq_n | output | 1 | Active-low interrupt request |

## Verification
The assertions check on every cycle that a match in an interrupt-enabled mode lowers the interrupt on the next edge. They also check that the interrupt stays low until acknowledged and never falls without a qualifying match. Two more cycle-level checks: an acknowledge restores the normal bank and releases the interrupt, and a bank-enabled match puts the forced bank on the output.

Only the bench scenarios can show the decode boundaries: the ignored low address bits, a wrong table bit, the upper region bit and a dropped strobe. The same holds for the fixed register map, the acknowledge winning over a simultaneous match, and the forced bank being rewritten while an override is active.

// File: rtl/htt_pkg.sv
package htt_pkg;
   // Bit positions inside the mode register.
   localparam int MODE_FORCE_BIT = 0;
   localparam int MODE_IRQ_BIT   = 1;
   localparam int MODE_TBL_BIT   = 2;
   localparam int MODE_W         = 3;

   typedef struct packed {
      logic tbl_sel;
      logic irq_en;
      logic force_en;
   } htt_mode_t;
endpackage

// File: rtl/htt_regs.sv
module htt_regs
   import htt_pkg::*;
#(
   parameter int NUM_HOT = 2,
   parameter int TILE_W  = 8,
   parameter int BANK_W  = 4,
   parameter int CPU_DW  = 8,
   parameter int AW      = 3
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic [AW-1:0]                  wr_addr,
   input  logic [CPU_DW-1:0]              wr_data,
   output logic [NUM_HOT-1:0][TILE_W-1:0] hot_tiles,
   output logic [BANK_W-1:0]              forced_bank,
   output htt_mode_t                      mode,
   output logic                           ack
);
   localparam int BANK_ADDR = NUM_HOT;
   localparam int MODE_ADDR = NUM_HOT + 1;
   localparam int ACK_ADDR  = NUM_HOT + 2;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_HOT; gi++) begin : g_hot
         always_ff @(posedge clk) begin
            if (!rst_n)
               hot_tiles[gi] <= '0;
            else if (wr_en && wr_addr == AW'(gi))
               hot_tiles[gi] <= wr_data[TILE_W-1:0];
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         forced_bank <= '0;
         mode        <= '0;
      end else if (wr_en) begin
         if (wr_addr == AW'(BANK_ADDR))
            forced_bank <= wr_data[BANK_W-1:0];
         if (wr_addr == AW'(MODE_ADDR))
            mode <= htt_mode_t'(wr_data[MODE_W-1:0]);
      end
   end

   assign ack = wr_en && (wr_addr == AW'(ACK_ADDR));
endmodule

// File: rtl/htt_match.sv
module htt_match #(
   parameter int NUM_HOT = 2,
   parameter int TILE_W  = 8,
   parameter int GA_W    = 14,
   parameter int ROW_W   = 4
) (
   input  logic [GA_W-1:0]                gfx_addr,
   input  logic                           gfx_rd,
   input  logic [NUM_HOT-1:0][TILE_W-1:0] hot_tiles,
   input  logic                           tbl_sel,
   output logic                           hit
);
   localparam int TBL_POS = ROW_W + TILE_W;
   localparam int UP_W    = GA_W - TBL_POS - 1;

   logic [TILE_W-1:0]  tile_no;
   logic               region_ok;
   logic [NUM_HOT-1:0] slot_eq;

   assign tile_no = gfx_addr[TBL_POS-1:ROW_W];

   generate
      if (UP_W > 0) begin : g_region
         assign region_ok = (gfx_addr[GA_W-1:TBL_POS+1] == '0);
      end else begin : g_noregion
         assign region_ok = 1'b1;
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_HOT; gi++) begin : g_cmp
         assign slot_eq[gi] = (tile_no == hot_tiles[gi]);
      end
   endgenerate

   assign hit = gfx_rd && region_ok && (gfx_addr[TBL_POS] == tbl_sel) && (|slot_eq);
endmodule

// File: rtl/htt_latch.sv
module htt_latch
   import htt_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      hit,
   input  htt_mode_t mode,
   input  logic      ack,
   output logic      force_act,
   output logic      irq_act
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         force_act <= 1'b0;
         irq_act   <= 1'b0;
      end else if (ack) begin
         force_act <= 1'b0;
         irq_act   <= 1'b0;
      end else if (hit) begin
         if (mode.force_en) force_act <= 1'b1;
         if (mode.irq_en)   irq_act   <= 1'b1;
      end
   end
endmodule

// File: rtl/hot_tile_trigger.sv
module hot_tile_trigger
   import htt_pkg::*;
#(
   parameter int NUM_HOT = 2,
   parameter int TILE_W  = 8,
   parameter int BANK_W  = 4,
   parameter int GA_W    = 14,
   parameter int ROW_W   = 4,
   parameter int CPU_DW  = 8,
   parameter int AW      = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_wr_en,
   input  logic [AW-1:0]     cpu_wr_addr,
   input  logic [CPU_DW-1:0] cpu_wr_data,
   input  logic [GA_W-1:0]   gfx_addr,
   input  logic              gfx_rd,
   input  logic [BANK_W-1:0] base_bank,
   output logic [BANK_W-1:0] bank_out,
   output logic              irq_n
);
   localparam int NUM_REGS = NUM_HOT + 3;

   generate
      if ((1 << AW) < NUM_REGS) begin : g_bad_aw
         $error("AW too small for register map");
      end
      if (CPU_DW < TILE_W || CPU_DW < BANK_W || CPU_DW < MODE_W) begin : g_bad_dw
         $error("CPU_DW narrower than a register");
      end
      if (GA_W < ROW_W + TILE_W + 1) begin : g_bad_ga
         $error("GA_W cannot hold row, tile and table bits");
      end
      if (NUM_HOT < 1) begin : g_bad_hot
         $error("NUM_HOT must be at least 1");
      end
   endgenerate

   logic [NUM_HOT-1:0][TILE_W-1:0] hot_w;
   logic [BANK_W-1:0]              fbank_w;
   htt_mode_t                      mode_w;
   logic                           ack_w;
   logic                           hit_w;
   logic                           force_act;
   logic                           irq_act;

   htt_regs #(
      .NUM_HOT(NUM_HOT), .TILE_W(TILE_W), .BANK_W(BANK_W),
      .CPU_DW(CPU_DW), .AW(AW)
   ) u_regs (
      .clk(clk), .rst_n(rst_n),
      .wr_en(cpu_wr_en), .wr_addr(cpu_wr_addr), .wr_data(cpu_wr_data),
      .hot_tiles(hot_w), .forced_bank(fbank_w), .mode(mode_w), .ack(ack_w)
   );

   htt_match #(
      .NUM_HOT(NUM_HOT), .TILE_W(TILE_W), .GA_W(GA_W), .ROW_W(ROW_W)
   ) u_match (
      .gfx_addr(gfx_addr), .gfx_rd(gfx_rd), .hot_tiles(hot_w),
      .tbl_sel(mode_w.tbl_sel), .hit(hit_w)
   );

   htt_latch u_latch (
      .clk(clk), .rst_n(rst_n), .hit(hit_w), .mode(mode_w), .ack(ack_w),
      .force_act(force_act), .irq_act(irq_act)
   );

   assign bank_out = force_act ? fbank_w : base_bank;
   assign irq_n    = ~irq_act;
endmodule

// File: rtl/htt_checker.sv
module htt_checker #(
   parameter int BANK_W = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              hit,
   input logic [2:0]        mode,
   input logic              ack,
   input logic [BANK_W-1:0] fbank,
   input logic [BANK_W-1:0] base_bank,
   input logic [BANK_W-1:0] bank_out,
   input logic              irq_n
);
   AST_IRQ_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode[1] && !ack) |=> !irq_n); // R5

   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_n && !ack) |=> !irq_n); // R5

   AST_NO_SPURIOUS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_n && !(hit && mode[1])) |=> irq_n); // R8

   AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> (irq_n && bank_out == base_bank)); // R7

   AST_FORCE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (hit && mode[0] && !ack) |=> (!$stable(fbank) || bank_out == fbank)); // R4
endmodule

bind hot_tile_trigger htt_checker #(.BANK_W(BANK_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .hit(hit_w), .mode(mode_w), .ack(ack_w),
   .fbank(fbank_w), .base_bank(base_bank), .bank_out(bank_out), .irq_n(irq_n)
);

// File: tb/hot_tile_trigger_tb.sv
module hot_tile_trigger_tb;
   localparam int A_HOT0 = 0, A_HOT1 = 1, A_BANK = 2, A_MODE = 3, A_ACK = 4;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        cpu_wr_en = 0;
   logic [2:0]  cpu_wr_addr = 0;
   logic [7:0]  cpu_wr_data = 0;
   logic [13:0] gfx_addr = 0;
   logic        gfx_rd = 0;
   logic [3:0]  base_bank = 4'h5;
   logic [3:0]  bank_out;
   logic        irq_n;
   int          n_chk = 0;
   int          n_bad = 0;

   always #2 clk = ~clk;

   hot_tile_trigger u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_wr_en(cpu_wr_en), .cpu_wr_addr(cpu_wr_addr),
      .cpu_wr_data(cpu_wr_data), .gfx_addr(gfx_addr), .gfx_rd(gfx_rd),
      .base_bank(base_bank), .bank_out(bank_out), .irq_n(irq_n)
   );

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input int a, input int d);
      cpu_wr_en = 1; cpu_wr_addr = 3'(a); cpu_wr_data = 8'(d);
      @(negedge clk);
      cpu_wr_en = 0;
   endtask

   task automatic fetch(input logic [13:0] a, input logic rd);
      gfx_addr = a; gfx_rd = rd;
      @(negedge clk);
      gfx_rd = 0;
   endtask

   task automatic t_reset();
      chk("R1 irq_n after reset", irq_n, 1);
      chk("R1 bank after reset", bank_out, 5);
      base_bank = 4'h9; #1;
      chk("R10 bank follows base", bank_out, 9);
      fetch(14'h0000, 1); // tile 0 equals reset hot tile, mode 0
      chk("R8 reset mode ignores match irq", irq_n, 1);
      chk("R8 reset mode ignores match bank", bank_out, 9);
   endtask

   task automatic t_force();
      wr(A_HOT0, 8'h3C); wr(A_BANK, 8'h0A); wr(A_MODE, 3'b001);
      fetch(14'h03C7, 1);
      chk("R4 forced bank after match", bank_out, 4'hA);
      chk("R4 irq untouched in force mode", irq_n, 1);
      base_bank = 4'h2; #1;
      chk("R4 override holds over base change", bank_out, 4'hA);
      wr(A_ACK, 0);
      chk("R7 release restores base", bank_out, 4'h2);
      fetch(14'h03C0, 1); // R2 different low bits still match
      chk("R2 low bits ignored", bank_out, 4'hA);
      wr(A_ACK, 0);
   endtask

   task automatic t_irq();
      wr(A_HOT1, 8'h81); wr(A_MODE, 3'b110);
      fetch(14'h1810, 1);
      chk("R5 irq low after match", irq_n, 0);
      chk("R5 bank not forced in irq mode", bank_out, 4'h2);
      @(negedge clk);
      chk("R5 irq held", irq_n, 0);
      wr(A_ACK, 0);
      chk("R7 irq released", irq_n, 1);
   endtask

   task automatic t_both();
      wr(A_MODE, 3'b011); wr(A_BANK, 8'h0C);
      fetch(14'h03CF, 1);
      chk("R6 combined irq", irq_n, 0);
      chk("R6 combined bank", bank_out, 4'hC);
      wr(A_BANK, 8'h07);
      chk("R9 new forced bank visible", bank_out, 4'h7);
      wr(A_ACK, 0);
      chk("R7 combined release irq", irq_n, 1);
      chk("R7 combined release bank", bank_out, 4'h2);
   endtask

   task automatic t_miss();
      fetch(14'h13C0, 1);
      chk("R3 wrong table irq", irq_n, 1);
      fetch(14'h03D0, 1);
      chk("R3 wrong tile irq", irq_n, 1);
      fetch(14'h03C0, 0);
      chk("R3 no strobe irq", irq_n, 1);
      fetch(14'h23C0, 1);
      chk("R3 upper region irq", irq_n, 1);
      chk("R3 upper region bank", bank_out, 4'h2);
   endtask

   task automatic t_off();
      wr(A_MODE, 3'b000);
      fetch(14'h03C0, 1);
      chk("R8 off mode irq", irq_n, 1);
      chk("R8 off mode bank", bank_out, 4'h2);
   endtask

   task automatic t_ack_wins();
      wr(A_MODE, 3'b011);
      cpu_wr_en = 1; cpu_wr_addr = 3'(A_ACK); gfx_addr = 14'h03C0; gfx_rd = 1;
      @(negedge clk);
      cpu_wr_en = 0; gfx_rd = 0;
      chk("R7 ack beats match irq", irq_n, 1);
      chk("R7 ack beats match bank", bank_out, 4'h2);
   endtask

   task automatic t_map();
      wr(A_HOT0, 8'h00); wr(A_HOT1, 8'h55); wr(A_MODE, 3'b001); wr(A_BANK, 8'h03);
      fetch(14'h0550, 1);
      chk("R11 slot1 address and bank field", bank_out, 4'h3);
      wr(A_ACK, 0);
   endtask

   initial begin
      #(4 * 20000);
      n_bad++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      @(negedge clk); @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_force();
      t_irq();
      t_both();
      t_miss();
      t_off();
      t_ack_wins();
      t_map();
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule